// File: doc/BRIEF.md
# Activity-Blanking Status LED Controller

This block drives a single front-panel indicator from three sources: a slow blink level that toggles about once per second, a steady "link healthy" level, and a one-cycle activity pulse (for example the OR of the transmit and receive start-of-packet strobes of a lane). While the link is unhealthy the indicator copies the blink level. While it is healthy the indicator stays lit. Each activity pulse makes the indicator go dark for a fixed number of millisecond strobes and then stay lit for at least as many strobes, so that each packet shows up as a short, visible flicker.

Time is taken from an external strobe that is high for one clock once per millisecond. The interval length is the parameter `MS_COUNT`: 100 on hardware and small values in simulation. Activity that arrives while a flicker is still being shown is remembered and served when the lit part of that flicker ends. Any number of such pulses collapse into one further flicker.

Top module: `flicker_led_ctrl`

## Requirements
- R1: While reset is asserted, and on the first clock after its synchronised release, `led` is 0.
- R2: With `status_ok` = 0 and no flicker in progress, `led` equals the `blink_in` value sampled one clock earlier.
- R3: With `status_ok` = 1 and no flicker in progress, `led` is 1 one clock later.
- R4: An `activity` pulse sampled while no flicker is in progress drives `led` to 0 from the next clock. `led` stays 0 until the clock after the `MS_COUNT`-th `ms_tick` pulse that follows.
- R5: After the dark interval, `led` is 1 until the clock after `MS_COUNT` further `ms_tick` pulses, whatever `status_ok` and `blink_in` do.
- R6: Clocks without `ms_tick` do not advance the dark or lit interval.
- R7: An `activity` pulse during the dark or lit interval is not lost. When the lit interval ends, `led` goes to 0 at once and a new dark interval begins.
- R8: Several `activity` pulses during one flicker produce exactly one further flicker. After that flicker `led` returns to status behaviour.
- R9: If `status_ok` falls during a flicker, the flicker still completes. `led` then follows `blink_in` as in R2.
- R10: The interval counter never exceeds `MS_COUNT`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ms_tick | input | 1 | One-clock strobe, once per millisecond |
| blink_in | input | 1 | Slow blink level, shown while the link is unhealthy |
| status_ok | input | 1 | Link-healthy level |
| activity | input | 1 | One-clock activity pulse |
| led | output | 1 | Indicator drive, 1 = lit |

## Verification
The hardest case to reach from the ports is a pending event that is served exactly at the boundary where the lit interval expires. It must also be shown that several pulses inside one flicker produce only one extra flicker. The bench controls `ms_tick` directly with `MS_COUNT` set to 3. It places activity pulses inside the dark interval and inside the lit interval, on clocks that carry no strobe. It then counts strobes one at a time and samples `led` after each, so that the clock on which the indicator re-darkens, and the clock on which it returns to steady or blink behaviour, are both pinned down.

// File: rtl/flicker_led_pkg.sv
package flicker_led_pkg;
  typedef enum logic [1:0] {
    ST_FOLLOW = 2'd0,
    ST_DARK   = 2'd1,
    ST_HOLD   = 2'd2
  } blank_state_e;
endpackage

// File: rtl/flicker_rst_sync.sv
module flicker_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_async,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_async) begin
    if (!rst_n_async) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/flicker_ms_timer.sv
module flicker_ms_timer #(
  parameter int MS_COUNT = 100,
  parameter int CNT_W    = $clog2(MS_COUNT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             ms_tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MS_COUNT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = run & ms_tick & (cnt_q == LAST);
  assign cnt_en = restart | (run & ms_tick);

  always_comb begin
    if (restart || done) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/flicker_blank_fsm.sv
module flicker_blank_fsm
  import flicker_led_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         activity,
  input  logic         status_ok,
  input  logic         blink_in,
  input  logic         done,
  output logic         run,
  output logic         restart,
  output logic         led,
  output blank_state_e st_o,
  output logic         pend_o
);
  blank_state_e st_q, st_d;
  logic         pend_q, pend_d;
  logic         led_q, led_d;

  always_comb begin
    st_d    = st_q;
    pend_d  = pend_q;
    restart = 1'b0;
    case (st_q)
      ST_FOLLOW: begin
        if (activity || pend_q) begin
          st_d    = ST_DARK;
          pend_d  = 1'b0;
          restart = 1'b1;
        end
      end
      ST_DARK: begin
        if (activity) pend_d = 1'b1;
        if (done) begin
          st_d    = ST_HOLD;
          restart = 1'b1;
        end
      end
      ST_HOLD: begin
        if (activity) pend_d = 1'b1;
        if (done) begin
          if (pend_d) begin
            st_d    = ST_DARK;
            pend_d  = 1'b0;
            restart = 1'b1;
          end else begin
            st_d = ST_FOLLOW;
          end
        end
      end
      default: begin
        st_d   = ST_FOLLOW;
        pend_d = 1'b0;
      end
    endcase

    case (st_d)
      ST_DARK: led_d = 1'b0;
      ST_HOLD: led_d = 1'b1;
      default: led_d = status_ok | blink_in;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_FOLLOW;
      pend_q <= 1'b0;
      led_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      pend_q <= pend_d;
      led_q  <= led_d;
    end
  end

  assign run    = (st_q != ST_FOLLOW);
  assign led    = led_q;
  assign st_o   = st_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/flicker_led_ctrl.sv
module flicker_led_ctrl
  import flicker_led_pkg::*;
#(
  parameter int MS_COUNT = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic blink_in,
  input  logic status_ok,
  input  logic activity,
  output logic led
);
  localparam int CNT_W = $clog2(MS_COUNT + 1);

  logic             rst_n_sync;
  logic             run, restart, done;
  logic [CNT_W-1:0] cnt;
  blank_state_e     st;
  logic             pend;

  flicker_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk         (clk),
    .rst_n_async (rst_n),
    .rst_n_sync  (rst_n_sync)
  );

  flicker_ms_timer #(.MS_COUNT(MS_COUNT), .CNT_W(CNT_W)) i_timer (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .restart (restart),
    .run     (run),
    .ms_tick (ms_tick),
    .cnt_o   (cnt),
    .done    (done)
  );

  flicker_blank_fsm i_fsm (
    .clk       (clk),
    .rst_n     (rst_n_sync),
    .activity  (activity),
    .status_ok (status_ok),
    .blink_in  (blink_in),
    .done      (done),
    .run       (run),
    .restart   (restart),
    .led       (led),
    .st_o      (st),
    .pend_o    (pend)
  );
endmodule

// File: rtl/flicker_led_chk.sv
module flicker_led_chk
  import flicker_led_pkg::*;
#(
  parameter int MS_COUNT = 100,
  parameter int CNT_W    = $clog2(MS_COUNT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ms_tick,
  input logic             status_ok,
  input logic             activity,
  input logic             led,
  input blank_state_e     st,
  input logic             pend,
  input logic [CNT_W-1:0] cnt
);
  logic past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  AST_STEADY_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && st == ST_FOLLOW && $past(status_ok)) |-> led); // R3

  AST_EVENT_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FOLLOW && activity) |=> !led); // R4

  AST_DARK_IS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DARK) |-> !led); // R4

  AST_HOLD_IS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HOLD) |-> led); // R5

  AST_HOLD_AFTER_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(st) == ST_DARK && st != ST_DARK) |-> (st == ST_HOLD)); // R5

  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FOLLOW && !ms_tick) |=> $stable(cnt)); // R6

  AST_PENDING_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_FOLLOW && activity) |=> (pend || st == ST_DARK)); // R7

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cnt) <= MS_COUNT - 1)); // R10
endmodule

bind flicker_led_ctrl flicker_led_chk #(.MS_COUNT(MS_COUNT), .CNT_W(CNT_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .ms_tick   (ms_tick),
  .status_ok (status_ok),
  .activity  (activity),
  .led       (led),
  .st        (st),
  .pend      (pend),
  .cnt       (cnt)
);

// File: tb/test_flicker_led_ctrl.sv
`timescale 1ns/1ps
module test_flicker_led_ctrl;
  localparam int N = 3;

  logic clk = 1'b0;
  logic rst_n, ms_tick, blink_in, status_ok, activity;
  logic led;
  int   n_checks = 0;
  int   n_fail   = 0;
  int   cycles   = 0;

  always #5 clk = ~clk;

  flicker_led_ctrl #(.MS_COUNT(N)) i_flicker_led_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ms_tick   (ms_tick),
    .blink_in  (blink_in),
    .status_ok (status_ok),
    .activity  (activity),
    .led       (led)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: led actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    ms_tick = 1'b1;
    step();
    ms_tick = 1'b0;
  endtask

  task automatic pulse();
    activity = 1'b1;
    step();
    activity = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; status_ok = 1'b1; blink_in = 1'b1;
    step(); step();
    chk(led, 1'b0, "R1 during reset");
    rst_n = 1'b1;
    step();
    chk(led, 1'b0, "R1 first clock after release");
    step(); step();
  endtask

  task automatic t_blink();
    status_ok = 1'b0;
    blink_in = 1'b1; step();
    chk(led, 1'b1, "R2 blink high");
    blink_in = 1'b0; step();
    chk(led, 1'b0, "R2 blink low");
    blink_in = 1'b1; step();
    chk(led, 1'b1, "R2 blink high again");
  endtask

  task automatic t_steady();
    status_ok = 1'b1; blink_in = 1'b0; step();
    chk(led, 1'b1, "R3 steady on");
    step(); step();
    chk(led, 1'b1, "R3 steady on held");
  endtask

  task automatic t_flicker();
    status_ok = 1'b1; blink_in = 1'b0;
    pulse();
    chk(led, 1'b0, "R4 dark after event");
    for (int i = 0; i < N - 1; i++) begin
      tick();
      chk(led, 1'b0, "R4 dark before last tick");
    end
    step(); step(); step();
    chk(led, 1'b0, "R6 no strobe no progress dark");
    tick();
    chk(led, 1'b1, "R4 lit after last dark tick");
    status_ok = 1'b0;
    for (int i = 0; i < N - 1; i++) begin
      tick();
      chk(led, 1'b1, "R5 lit held despite status low");
    end
    step(); step();
    chk(led, 1'b1, "R6 no strobe no progress lit");
    tick();
    chk(led, 1'b0, "R5 back to blink (low) after hold");
    status_ok = 1'b1; step();
    chk(led, 1'b1, "R3 steady after flicker");
  endtask

  task automatic t_pending_hold();
    status_ok = 1'b1;
    pulse();
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b1, "R7 in lit interval");
    pulse();
    chk(led, 1'b1, "R7 event in lit interval does not blank");
    for (int i = 0; i < N - 1; i++) tick();
    chk(led, 1'b1, "R7 still lit before end");
    tick();
    chk(led, 1'b0, "R7 pending event darkens at end of lit");
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b1, "R7 second flicker lit");
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b1, "R7 back to steady");
  endtask

  task automatic t_multi();
    status_ok = 1'b1;
    pulse();
    pulse();
    tick();
    pulse();
    for (int i = 0; i < N - 1; i++) tick();
    chk(led, 1'b1, "R8 lit after first dark");
    pulse();
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b0, "R8 one extra flicker dark");
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b1, "R8 extra flicker lit");
    status_ok = 1'b0; blink_in = 1'b0;
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b0, "R8 no third flicker, blink low");
    step();
    chk(led, 1'b0, "R8 stays in status mode");
  endtask

  task automatic t_status_drop();
    status_ok = 1'b1; blink_in = 1'b0;
    pulse();
    status_ok = 1'b0;
    tick();
    chk(led, 1'b0, "R9 dark continues after status drop");
    for (int i = 0; i < N - 1; i++) tick();
    chk(led, 1'b1, "R9 lit interval still shown");
    for (int i = 0; i < N; i++) tick();
    chk(led, 1'b0, "R9 follows blink low after sequence");
    blink_in = 1'b1; step();
    chk(led, 1'b1, "R9 follows blink high");
  endtask

  initial begin
    ms_tick = 1'b0; activity = 1'b0; blink_in = 1'b0; status_ok = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_blink();
    t_steady();
    t_flicker();
    t_pending_hold();
    t_multi();
    t_status_drop();
    summary();
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=done");
        summary();
      end
    end
  end
endmodule